// File: doc/BRIEF.md
# Shadowed Real-Time Clock Register Port

This block connects a byte-wide host register port to a set of running timekeeping counters. These are seconds, minutes and hours in 24-hour BCD, plus a control byte. Reads never see the live counters. They see a private copy that is reloaded at three moments: a bus start event, a bus stop event, or the auto-incrementing register pointer wrapping back to address zero. A burst read therefore returns one consistent time, even if a second boundary passes in the middle of the burst.

Host writes are first captured together with the pointer value. They reach the live counters only on the acknowledge pulse that follows. A transferred write to the seconds register also clears the sub-second prescaler. This restarts the current second and moves the phase of the 1 Hz square-wave output so that it lines up with the write. The prescaler divides the input clock by a parameter, so the same block serves any oscillator frequency.

Top module: `rtc_shadow_port`

## Requirements
- R1: After synchronous reset, `rd_data`, `sqw_out` and `sec_tick` are 0, the pointer is 0, every live register and every buffered copy reads 0x00, and the prescaler count is 0.
- R2: Register map: address 0 holds seconds (BCD 00–59), 1 holds minutes (BCD 00–59), 2 holds hours (BCD 00–23), and 3 is control, where bit 0 enables the square wave. `ptr_set` loads the pointer from `ptr_in`. Each `rd_stb` or `wr_stb` then advances the pointer by one, and address 3 wraps to 0.
- R3: A read returns the buffered copy of the addressed register. The copy is reloaded from the live registers on the clock edge that samples `bus_start`, `bus_stop`, or an advance that wraps the pointer to 0. Live counting between reloads does not change the returned values, and `ptr_set` does not cause a reload.
- R4: `rd_data` updates on the clock edge that samples `rd_stb` and holds that value until the next `rd_stb`.
- R5: `wr_stb` captures `wr_data` for the current pointer address. The byte enters the live register on the edge that samples `wr_ack`. An ack with no captured byte pending changes nothing, and a captured byte without an ack changes nothing.
- R6: A transferred seconds write clears the prescaler. The next `sec_tick` pulse is high during the cycle after the CLK_HZ-th rising edge that follows the acknowledge edge.
- R7: A transferred write to minutes, hours or control leaves the prescaler phase unchanged.
- R8: Each tick advances seconds in BCD. 59 goes to 00 and carries into minutes, minutes 59 goes to 00 and carries into hours, and hours 23 goes to 00.
- R9: With control bit 0 set and `osc_run` high, `sqw_out` is low for the first CLK_HZ/2 prescaler counts of each second and high for the rest. After a seconds write it first rises CLK_HZ/2+1 edges after the acknowledge edge. With bit 0 clear it stays low.
- R10: While `osc_run` is low, the prescaler and the time registers hold their values and `sec_tick` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the prescaler counts its rising edges |
| rst | input | 1 | Synchronous active-high reset |
| osc_run | input | 1 | Oscillator running; gates the prescaler |
| bus_start | input | 1 | One-cycle pulse on a bus start event |
| bus_stop | input | 1 | One-cycle pulse on a bus stop event |
| ptr_set | input | 1 | Load register pointer from `ptr_in` |
| ptr_in | input | 2 | New register pointer value |
| rd_stb | input | 1 | Read one byte at the pointer, then advance |
| rd_data | output | 8 | Registered read byte |
| wr_stb | input | 1 | Capture `wr_data` for the pointer, then advance |
| wr_data | input | 8 | Write byte |
| wr_ack | input | 1 | Acknowledge pulse; transfers the captured byte |
| sec_tick | output | 1 | One-cycle pulse per elapsed second |
| sqw_out | output | 1 | 1 Hz square wave, registered |

## Verification
Faults in the buffered copy are only visible through reads. If a reload is missing or happens at the wrong moment, the next burst returns a seconds value one count off from what the stimulus predicts. The bench therefore runs the oscillator for exactly one prescaler period between reads and checks both the stale value and the refreshed one. A prescaler that is not cleared, or is cleared by the wrong register, moves the `sec_tick` pulse by several cycles within one period. The bench counts edges from the acknowledge edge to the exact cycle of that pulse, and does the same for the square-wave rise and fall. A BCD carry fault shows at the first read after the 23:59:59 rollover.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int NREG  = 4;
  localparam int PTR_W = $clog2(NREG);

  localparam logic [PTR_W-1:0] A_SEC  = PTR_W'(0);
  localparam logic [PTR_W-1:0] A_MIN  = PTR_W'(1);
  localparam logic [PTR_W-1:0] A_HOUR = PTR_W'(2);
  localparam logic [PTR_W-1:0] A_CTRL = PTR_W'(3);
  localparam logic [PTR_W-1:0] A_LAST = PTR_W'(NREG - 1);

  localparam logic [7:0] SEC_MAX  = 8'h59;
  localparam logic [7:0] MIN_MAX  = 8'h59;
  localparam logic [7:0] HOUR_MAX = 8'h23;

  typedef struct packed {
    logic       carry;
    logic [7:0] val;
  } bcd_step_t;

  // One BCD increment with rollover to zero past the limit.
  function automatic bcd_step_t bcd_step(input logic [7:0] cur, input logic [7:0] lim);
    bcd_step_t r;
    if (cur >= lim) begin
      r.carry = 1'b1;
      r.val   = 8'h00;
    end else if (cur[3:0] >= 4'h9) begin
      r.carry = 1'b0;
      r.val   = {cur[7:4] + 4'h1, 4'h0};
    end else begin
      r.carry = 1'b0;
      r.val   = {cur[7:4], cur[3:0] + 4'h1};
    end
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CLK_HZ = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  input  logic sqw_en,
  output logic tick_now,
  output logic tick_q,
  output logic sqw_q
);
  localparam int            CW   = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);
  localparam logic [CW-1:0] HALF = CW'(CLK_HZ / 2);

  logic [CW-1:0] cnt;

  // A clear in the same cycle wins over the end-of-second tick.
  assign tick_now = run && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_q <= 1'b0;
      sqw_q  <= 1'b0;
    end else begin
      tick_q <= tick_now;
      sqw_q  <= sqw_en && run && (cnt >= HALF);
      if (clr)
        cnt <= '0;
      else if (run)
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_shadow_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      wr_en,
  input  logic [PTR_W-1:0]          wr_addr,
  input  logic [7:0]                wr_data,
  output logic [NREG-1:0][7:0]      live
);
  bcd_step_t s_step, m_step, h_step;

  always_comb begin
    s_step = bcd_step(live[A_SEC],  SEC_MAX);
    m_step = bcd_step(live[A_MIN],  MIN_MAX);
    h_step = bcd_step(live[A_HOUR], HOUR_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else begin
      if (tick) begin
        live[A_SEC] <= s_step.val;
        if (s_step.carry) begin
          live[A_MIN] <= m_step.val;
          if (m_step.carry)
            live[A_HOUR] <= h_step.val;
        end
      end
      // A host transfer overrides the count for its own register.
      if (wr_en)
        live[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/rtc_host_buffer.sv
module rtc_host_buffer
  import rtc_shadow_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_start,
  input  logic                 bus_stop,
  input  logic                 ptr_set,
  input  logic [PTR_W-1:0]     ptr_in,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic [7:0]           wr_data,
  input  logic                 wr_ack,
  input  logic [NREG-1:0][7:0] live,
  output logic [7:0]           rd_data,
  output logic [PTR_W-1:0]     ptr,
  output logic                 xfer_en,
  output logic [PTR_W-1:0]     xfer_addr,
  output logic [7:0]           xfer_data
);
  logic [PTR_W-1:0] ptr_nxt;
  logic             advance;
  logic             wrap;
  logic             refresh;
  logic [7:0]       snap [NREG];
  logic             pend_v;

  assign advance = (rd_stb || wr_stb) && !ptr_set;
  assign ptr_nxt = (ptr == A_LAST) ? '0 : ptr + 1'b1;
  assign wrap    = advance && (ptr == A_LAST);
  assign refresh = bus_start || bus_stop || wrap;

  for (genvar g = 0; g < NREG; g++) begin : g_snap
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (refresh)
        q <= live[g];
    end
    assign snap[g] = q;
  end

  assign xfer_en = wr_ack && pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      rd_data   <= '0;
      pend_v    <= 1'b0;
      xfer_addr <= '0;
      xfer_data <= '0;
    end else begin
      if (ptr_set)
        ptr <= ptr_in;
      else if (advance)
        ptr <= ptr_nxt;
      if (rd_stb)
        rd_data <= snap[ptr];
      if (wr_stb) begin
        pend_v    <= 1'b1;
        xfer_addr <= ptr;
        xfer_data <= wr_data;
      end else if (xfer_en) begin
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_shadow_port.sv
module rtc_shadow_port
  import rtc_shadow_pkg::*;
#(
  parameter int CLK_HZ = 32768
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_run,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             ptr_set,
  input  logic [PTR_W-1:0] ptr_in,
  input  logic             rd_stb,
  output logic [7:0]       rd_data,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  input  logic             wr_ack,
  output logic             sec_tick,
  output logic             sqw_out
);
  logic [NREG-1:0][7:0] live;
  logic [PTR_W-1:0]     ptr;
  logic                 xfer_en;
  logic [PTR_W-1:0]     xfer_addr;
  logic [7:0]           xfer_data;
  logic                 tick_now;
  logic                 sec_clr;
  logic                 sqw_en;

  assign sec_clr = xfer_en && (xfer_addr == A_SEC);
  assign sqw_en  = live[A_CTRL][0];

  rtc_host_buffer u_host (
    .clk       (clk),
    .rst       (rst),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .ptr_set   (ptr_set),
    .ptr_in    (ptr_in),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .live      (live),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .xfer_en   (xfer_en),
    .xfer_addr (xfer_addr),
    .xfer_data (xfer_data)
  );

  rtc_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (osc_run),
    .clr      (sec_clr),
    .sqw_en   (sqw_en),
    .tick_now (tick_now),
    .tick_q   (sec_tick),
    .sqw_q    (sqw_out)
  );

  rtc_time_chain u_time (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_now),
    .wr_en   (xfer_en),
    .wr_addr (xfer_addr),
    .wr_data (xfer_data),
    .live    (live)
  );
endmodule

// File: rtl/rtc_shadow_port_chk.sv
module rtc_shadow_port_chk
  import rtc_shadow_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             osc_run,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic             ptr_set,
  input logic [PTR_W-1:0] ptr,
  input logic             xfer_en,
  input logic [PTR_W-1:0] xfer_addr,
  input logic             sqw_en,
  input logic             sec_tick,
  input logic             sqw_out,
  input logic [7:0]       rd_data
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sqw_out && !sec_tick && rd_data == 8'h00 && ptr == '0));

  assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (rst)
    ((rd_stb || wr_stb) && !ptr_set) |=>
      (ptr == (($past(ptr) == A_LAST) ? '0 : $past(ptr) + 1'b1)));

  assert_sec_write_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && xfer_addr == A_SEC) |=> !sec_tick);

  assert_sqw_off_R9: assert property (@(posedge clk) disable iff (rst)
    !sqw_en |=> !sqw_out);

  assert_osc_stop_R10: assert property (@(posedge clk) disable iff (rst)
    !osc_run |=> !sec_tick);
endmodule

bind rtc_shadow_port rtc_shadow_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .osc_run   (osc_run),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .ptr_set   (ptr_set),
  .ptr       (ptr),
  .xfer_en   (xfer_en),
  .xfer_addr (xfer_addr),
  .sqw_en    (sqw_en),
  .sec_tick  (sec_tick),
  .sqw_out   (sqw_out),
  .rd_data   (rd_data)
);

// File: tb/rtc_shadow_port_tb.sv
`timescale 1ns/1ps
module rtc_shadow_port_tb;
  localparam int HZ = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_run = 1'b0;
  logic       bus_start = 1'b0;
  logic       bus_stop = 1'b0;
  logic       ptr_set = 1'b0;
  logic [1:0] ptr_in = 2'd0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ack = 1'b0;
  logic       sec_tick;
  logic       sqw_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // {address, written byte, expected read-back}, oscillator stopped
  localparam logic [23:0] VEC [7] = '{
    24'h01_45_45, 24'h02_17_17, 24'h00_30_30, 24'h03_01_01,
    24'h01_07_07, 24'h02_23_23, 24'h03_00_00
  };

  always #2.5 clk = ~clk;

  rtc_shadow_port #(.CLK_HZ(HZ)) u_dut (
    .clk(clk), .rst(rst), .osc_run(osc_run), .bus_start(bus_start),
    .bus_stop(bus_stop), .ptr_set(ptr_set), .ptr_in(ptr_in),
    .rd_stb(rd_stb), .rd_data(rd_data), .wr_stb(wr_stb),
    .wr_data(wr_data), .wr_ack(wr_ack), .sec_tick(sec_tick),
    .sqw_out(sqw_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic set_ptr(input logic [1:0] a);
    ptr_set = 1'b1; ptr_in = a; @(negedge clk); ptr_set = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    chk(req, rd_data, exp);
  endtask

  // Ends on the falling edge right after the acknowledge edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    set_ptr(a);
    wr_stb = 1'b1; wr_data = d; @(negedge clk); wr_stb = 1'b0;
    wr_ack = 1'b1; @(negedge clk); wr_ack = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    osc_run = 1'b1; repeat (n) @(negedge clk); osc_run = 1'b0;
  endtask

  task automatic tick_at(input string req, input int quiet);
    logic early;
    early = 1'b0;
    for (int k = 0; k < quiet; k++) begin
      @(negedge clk);
      if (sec_tick) early = 1'b1;
    end
    chk({req, " no early tick"}, {7'd0, early}, 8'h00);
    @(negedge clk);
    chk({req, " tick"}, {7'd0, sec_tick}, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 sqw_out", {7'd0, sqw_out}, 8'h00);
    chk("R1 sec_tick", {7'd0, sec_tick}, 8'h00);
    pulse_start();
    for (int a = 0; a < 4; a++) rd("R1 register", 8'h00);

    // R5 R2: table of writes and read-backs, oscillator stopped
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      pulse_start();
      set_ptr(VEC[i][17:16]);
      rd("R5 R2 table read-back", VEC[i][7:0]);
    end

    // R8 R6: full rollover, tick timed from the seconds acknowledge
    osc_run = 1'b1;
    wr(2'd2, 8'h23);
    wr(2'd1, 8'h59);
    wr(2'd0, 8'h59);
    tick_at("R6", HZ - 1);
    osc_run = 1'b0;
    pulse_start();
    set_ptr(2'd0);
    rd("R8 seconds", 8'h00);
    rd("R8 minutes", 8'h00);
    rd("R8 hours", 8'h00);

    // R7: minutes write mid-second keeps phase
    osc_run = 1'b1;
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h12);
    tick_at("R7", HZ - 4);
    osc_run = 1'b0;
    pulse_start();
    set_ptr(2'd0);
    rd("R7 seconds", 8'h06);
    rd("R7 minutes", 8'h12);

    // R9: square wave phase after a seconds write
    wr(2'd3, 8'h01);
    osc_run = 1'b1;
    wr(2'd0, 8'h00);
    for (int k = 1; k <= HZ + 1; k++) begin
      @(negedge clk);
      chk("R9 sqw phase", {7'd0, sqw_out}, (k > HZ / 2 && k <= HZ) ? 8'h01 : 8'h00);
    end
    wr(2'd3, 8'h00);
    bad = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sqw_out) bad = 1'b1;
    end
    chk("R9 sqw disabled", {7'd0, bad}, 8'h00);
    osc_run = 1'b0;

    // R3 R2: buffered copy versus live count
    wr(2'd0, 8'h10);
    pulse_start();
    set_ptr(2'd0);
    rd("R3 first read", 8'h10);
    run_cycles(HZ);
    set_ptr(2'd0);
    rd("R3 stale after ptr_set", 8'h10);
    rd("R3 minutes", 8'h12);
    rd("R3 hours", 8'h00);
    rd("R3 control", 8'h00);
    rd("R3 R2 reload on wrap", 8'h11);
    run_cycles(HZ);
    set_ptr(2'd0);
    rd("R3 stale before stop", 8'h11);
    pulse_stop();
    set_ptr(2'd0);
    rd("R3 reload on stop", 8'h12);

    // R5: ack without a pending byte, then a byte without an ack
    wr_ack = 1'b1; @(negedge clk); wr_ack = 1'b0;
    pulse_start();
    set_ptr(2'd1);
    rd("R5 lone ack", 8'h12);
    set_ptr(2'd1);
    wr_stb = 1'b1; wr_data = 8'h33; @(negedge clk); wr_stb = 1'b0;
    pulse_start();
    set_ptr(2'd1);
    rd("R5 no ack yet", 8'h12);
    wr_ack = 1'b1; @(negedge clk); wr_ack = 1'b0;
    pulse_start();
    set_ptr(2'd1);
    rd("R5 after ack", 8'h33);

    // R10: stopped oscillator freezes time
    bad = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sec_tick) bad = 1'b1;
    end
    chk("R10 no tick", {7'd0, bad}, 8'h00);
    pulse_start();
    set_ptr(2'd0);
    rd("R10 seconds held", 8'h12);

    // R4: read byte holds across idle cycles and a reload
    repeat (5) @(negedge clk);
    pulse_start();
    chk("R4 rd_data held", rd_data, 8'h12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule